// File: doc/BRIEF.md
# Selectable Pin Event Detector

This block watches a single pin chosen from a wide input bus and raises a sticky event flag when a programmed condition occurs on it. The condition can be an edge (rising, falling or either) or a level (low or high). A 9-bit selector chooses both the condition and the pin. The selector bits are split into a 3-bit condition code in the upper bits and a 6-bit pin index in the lower bits.

The whole input bus passes through a two-flop synchroniser before the selected bit is compared with its previous sample. A consumer can clear the flag with an acknowledge pulse. It can also hold a wait request, which stalls until the flag is set. The wait completes in the cycle the flag is seen, and the flag is cleared at that point.

The edge and level conditions behave differently after a clear. A level condition fires again one cycle after a clear if the level is still present. An edge condition stays quiet until a fresh transition arrives.

Top module: `pin_event_detector`

## Requirements
- R1: On a rising clock edge with `sel_wr` high, `sel_in[8:6]` is loaded as the condition code and `sel_in[5:0]` as the pin index. After reset the condition code is 000.
- R2: With condition code 000 the detector is off and `flag` never sets, whatever the selected pin does.
- R3: Code 001 sets `flag` on a rising transition of the selected pin. Code 010 sets it on a falling transition. Code 011 sets it on either transition. A pin that does not change never sets `flag` in these codes.
- R4: Codes 100 and 101 set `flag` while the synchronised pin is low. Codes 110 and 111 set it while the pin is high. The lowest code bit (selector bit 6) has no effect.
- R5: A clear (`ack`, or a completed wait) has priority over a simultaneous event. In a level code, if the level still holds, `flag` reads 0 for exactly one cycle after the clear and is 1 again on the next cycle.
- R6: In an edge code, once `flag` is cleared it stays clear until a new qualifying transition reaches the synchroniser output.
- R7: A selector write clears `flag`. It also reloads the previous-sample register from the newly selected pin, so the level that pin already has causes no edge event.
- R8: `stall` is high while `wait_req` is high and `flag` is low. When `wait_req` is high and `flag` is high, `stall` is low and `flag` is cleared on that clock edge.
- R9: A change on a pin driven before rising edge 1 first shows in `flag` after rising edge 3. After edge 2 the flag still reads its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins | input | 64 | Asynchronous pin inputs |
| sel_wr | input | 1 | Load the selector |
| sel_in | input | 9 | Selector: [8:6] condition code, [5:0] pin index |
| ack | input | 1 | Clear the event flag |
| wait_req | input | 1 | Wait for an event; completes and clears the flag when the flag is set |
| flag | output | 1 | Sticky event flag |
| stall | output | 1 | Wait still pending |

## Verification
The bench walks every condition code, including code 101, with a transition in each direction. A decoder that read the lowest code bit would miss events, and one that confused rising with falling would fire on the wrong transition.

A level code is checked to fall for exactly one cycle after a clear and then set again. A design with the wrong clear priority would either never drop the flag or never set it again. An edge code is checked to stay quiet after a clear, which catches a design that latched the edge.

A selector write onto a pin that is already high must not produce a false rising event. The wait request is checked to complete and clear the flag together. The flag is sampled after the second and third clock edges to catch a synchroniser with one stage too few or too many.

// File: rtl/pin_event_detector.sv
module pin_event_detector #(
  parameter int NPINS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins,
  input  logic              sel_wr,
  input  logic [8:0]        sel_in,
  input  logic              ack,
  input  logic              wait_req,
  output logic              flag,
  output logic              stall
);
  localparam int PIN_W = $clog2(NPINS);

  logic [NPINS-1:0] sync_a, sync_b;
  logic [2:0]       mode_q;
  logic [PIN_W-1:0] pin_q;
  logic             prev_q, flag_q, hit;

  wire cur  = sync_b[pin_q];
  wire done = wait_req & flag_q;
  wire clr  = ack | done;

  always_comb begin
    case (mode_q)
      3'b001:          hit = cur & ~prev_q;
      3'b010:          hit = ~cur & prev_q;
      3'b011:          hit = cur ^ prev_q;
      3'b100, 3'b101:  hit = ~cur;
      3'b110, 3'b111:  hit = cur;
      default:         hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      mode_q <= '0;
      pin_q  <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sync_a <= pins;
      sync_b <= sync_a;
      if (sel_wr) begin
        mode_q <= sel_in[8:6];
        pin_q  <= sel_in[PIN_W-1:0];
        prev_q <= sync_b[sel_in[PIN_W-1:0]];
        flag_q <= 1'b0;
      end else begin
        prev_q <= cur;
        if (clr)      flag_q <= 1'b0;
        else if (hit) flag_q <= 1'b1;
      end
    end
  end

  assign flag  = flag_q;
  assign stall = wait_req & ~flag_q;

  a_r2_off_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b000) |-> !flag_q);

  a_r3_rise_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && mode_q == 3'b001 && !$past(sel_wr)) |-> ($past(cur) && !$past(prev_q)));

  a_r5_level_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2] && !sel_wr && !ack && !wait_req && cur == mode_q[1]) |=> flag_q);

  a_r6_edge_needs_transition: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !mode_q[2] && cur == prev_q && !sel_wr) |=> !flag_q);

  a_r7_select_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> !flag_q);

  a_r8_wait_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && flag_q && !sel_wr) |=> !flag_q);
endmodule

// File: tb/sim_pin_event_detector.sv
module sim_pin_event_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pins = '0;
  logic        sel_wr = 1'b0;
  logic [8:0]  sel_in = '0;
  logic        ack = 1'b0;
  logic        wait_req = 1'b0;
  logic        flag, stall;
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  pin_event_detector u0 (.clk(clk), .rst_n(rst_n), .pins(pins), .sel_wr(sel_wr),
    .sel_in(sel_in), .ack(ack), .wait_req(wait_req), .flag(flag), .stall(stall));

  // {code[2:0], pin[5:0], start level, new level, expected flag}
  localparam logic [11:0] VEC [16] = '{
    {3'b001, 6'd5,  1'b0, 1'b1, 1'b1},
    {3'b001, 6'd5,  1'b1, 1'b0, 1'b0},
    {3'b010, 6'd63, 1'b1, 1'b0, 1'b1},
    {3'b010, 6'd63, 1'b0, 1'b1, 1'b0},
    {3'b011, 6'd0,  1'b0, 1'b1, 1'b1},
    {3'b011, 6'd0,  1'b1, 1'b0, 1'b1},
    {3'b011, 6'd7,  1'b0, 1'b0, 1'b0},
    {3'b100, 6'd9,  1'b1, 1'b0, 1'b1},
    {3'b101, 6'd9,  1'b1, 1'b0, 1'b1},
    {3'b100, 6'd9,  1'b1, 1'b1, 1'b0},
    {3'b110, 6'd9,  1'b0, 1'b1, 1'b1},
    {3'b111, 6'd9,  1'b0, 1'b1, 1'b1},
    {3'b111, 6'd9,  1'b0, 1'b0, 1'b0},
    {3'b000, 6'd1,  1'b0, 1'b1, 1'b0},
    {3'b000, 6'd1,  1'b1, 1'b1, 1'b0},
    {3'b001, 6'd40, 1'b0, 1'b1, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic select(input logic [2:0] code, input logic [5:0] pin);
    sel_in = {code, pin};
    sel_wr = 1'b1;
    step(1);
    sel_wr = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    step(2);
    check("R1 reset flag", flag, 1'b0);
    check("R1 reset stall", stall, 1'b0);
    rst_n = 1'b1;
    pins = '1;
    step(4);
    check("R1/R2 code 000 after reset", flag, 1'b0);
    pins = '0;
    step(3);

    for (int i = 0; i < 16; i++) begin
      logic [2:0] code;
      logic [5:0] pn;
      code = VEC[i][11:9];
      pn   = VEC[i][8:3];
      pins = '0;
      pins[pn] = VEC[i][2];
      step(3);
      select(code, pn);
      step(3);
      check($sformatf("R2/R3/R4 vec %0d before change", i), flag, 1'b0);
      pins[pn] = VEC[i][1];
      step(4);
      check($sformatf("R2/R3/R4 vec %0d after change", i), flag, VEC[i][0]);
    end

    // R9: synchroniser latency
    pins = '0;
    step(3);
    select(3'b001, 6'd12);
    step(2);
    pins[12] = 1'b1;
    step(2);
    check("R9 flag after edge 2", flag, 1'b0);
    step(1);
    check("R9 flag after edge 3", flag, 1'b1);

    // R6: the edge fires once
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    check("R6 cleared by ack", flag, 1'b0);
    step(5);
    check("R6 no refire without transition", flag, 1'b0);

    // R5: the level re-arms one cycle after a clear
    pins = '0;
    pins[3] = 1'b1;
    step(3);
    select(3'b110, 6'd3);
    step(3);
    check("R5 level set", flag, 1'b1);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    check("R5 low one cycle after clear", flag, 1'b0);
    step(1);
    check("R5 set again next cycle", flag, 1'b1);

    // R7: a selector write clears the flag and causes no false edge
    pins = '0;
    pins[10] = 1'b1;
    step(3);
    select(3'b011, 6'd11);
    step(1);
    select(3'b001, 6'd10);
    step(4);
    check("R7 no false edge from pin level", flag, 1'b0);
    pins[10] = 1'b0;
    step(3);
    check("R7 change after write seen", flag, 1'b0);
    pins[10] = 1'b1;
    step(3);
    check("R7 real rise seen", flag, 1'b1);
    select(3'b001, 6'd10);
    check("R7 write clears flag", flag, 1'b0);

    // R8: wait request
    pins = '0;
    step(3);
    select(3'b001, 6'd2);
    wait_req = 1'b1;
    step(2);
    check("R8 stall while no event", stall, 1'b1);
    pins[2] = 1'b1;
    step(2);
    check("R8 still stalled", stall, 1'b1);
    step(1);
    check("R8 flag seen", flag, 1'b1);
    check("R8 stall released", stall, 1'b0);
    step(1);
    check("R8 flag consumed by wait", flag, 1'b0);
    check("R8 stall again", stall, 1'b1);
    wait_req = 1'b0;
    step(1);
    check("R8 no stall without wait", stall, 1'b0);

    finish_run();
  end
endmodule